// File: doc/BRIEF.md
# Operand Register Redirection Table

This block is a small associative table that sits between instruction decode and the register file. It can substitute a different physical register for an architectural register named by an instruction. Each slot holds one redirection entry. The key of an entry is a 5-bit register number plus a flag that selects the integer or floating-point bank. The value is a 7-bit target register, a vector/scalar indication and a 2-bit element-width override.

Entries are loaded through a write port, which carries a slot index, a format select and a 16-bit word. Two encodings are accepted. The compact one-byte form always marks the operand as a vector, and its target is the key register number shifted left by two. The full two-byte form names the 7-bit target explicitly and can force scalar treatment. Every operand lookup compares its key against all slots at once. The lookup is purely combinational, so decode can query the table in the same cycle that it extracts the register fields.

Top module: `regmap_table`

## Requirements
- R1: After reset every slot is empty, so every lookup misses until an entry is written.
- R2: On a miss, `hit` is 0, `outReg` is `lkReg` zero-extended to 7 bits, `outVec` is 0 and `outWidth` is 00.
- R3: An entry matches only when both its key register (word bits 4:0) and its bank bit (word bit 5, 1 = integer, 0 = floating point) equal `lkReg` and `lkIsInt`.
- R4: A compact entry (`wrFull` = 0) reports `outVec` = 1 and `outReg` = {key, 2'b00}; word bits 15:8 are ignored.
- R5: A full entry (`wrFull` = 1) reports `outReg` = word bits 14:8 and `outVec` = NOT word bit 15.
- R6: A hit reports `outWidth` equal to word bits 7:6 of the entry (00 default, 01 8-bit, 10 16-bit, 11 32-bit) in both formats.
- R7: When several slots match, the slot with the lowest index supplies the outputs.
- R8: A write becomes visible to lookups only after the next rising clock edge, and outputs react to lookup inputs in the same cycle.
- R9: Writing a slot that is already occupied replaces its old contents completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load the slot named by wrIdx |
| wrIdx | input | 2 | Slot index to load |
| wrFull | input | 1 | 1 = full two-byte format, 0 = compact one-byte format |
| wrData | input | 16 | Entry word |
| lkReg | input | 5 | Architectural register number being looked up |
| lkIsInt | input | 1 | 1 = integer bank, 0 = floating-point bank |
| hit | output | 1 | A slot matched |
| outReg | output | 7 | Register to use |
| outVec | output | 1 | Operand is a vector |
| outWidth | output | 2 | Element-width override code |

## Verification
The bench builds the table with its default of four slots. With that setting, every slot index can be written. Three slots can hold the same key at once, which exercises the priority order across more than two candidates. The default also lets an overwrite of slot 0 hand priority back to a higher slot. Register number 31 reaches the top of the key range, so the compact shift yields target 124 with no lost bits.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  localparam int KEY_W   = 5;
  localparam int TGT_W   = 7;
  localparam int WIDTH_W = 2;
  localparam int WORD_W  = 16;

  typedef struct packed {
    logic               valid;
    logic               isInt;
    logic [KEY_W-1:0]   key;
    logic [WIDTH_W-1:0] width;
    logic               isVec;
    logic [TGT_W-1:0]   target;
  } entry_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              loadStb;
    logic              fullFmt;
    logic [WORD_W-1:0] word;
  } ctl_t;

  function automatic entry_t decodeEntry(input logic fullFmt, input logic [WORD_W-1:0] w);
    entry_t e;
    e.valid = 1'b1;
    e.key   = w[KEY_W-1:0];
    e.isInt = w[5];
    e.width = w[7:6];
    if (fullFmt) begin
      e.target = w[14:8];
      e.isVec  = ~w[15];
    end else begin
      e.target = {w[KEY_W-1:0], 2'b00};
      e.isVec  = 1'b1;
    end
    return e;
  endfunction

endpackage

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic                   wrFull,
  input  logic [WORD_W-1:0]      wrData,
  output ctl_t                   ctl,
  output logic [NUM_ENTRIES-1:0] slotSel
);

  always_comb begin
    ctl.loadStb = wrEn;
    ctl.fullFmt = wrFull;
    ctl.word    = wrData;
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_sel
    assign slotSel[g] = wrEn && (wrIdx == IDX_W'(g));
  end

endmodule

// File: rtl/regmap_dp.sv
module regmap_dp
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_t                   ctl,
  input  logic [NUM_ENTRIES-1:0] slotSel,
  input  logic [KEY_W-1:0]       lkReg,
  input  logic                   lkIsInt,
  output logic                   hit,
  output logic [TGT_W-1:0]       outReg,
  output logic                   outVec,
  output logic [WIDTH_W-1:0]     outWidth
);

  entry_t                   slots [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]   match;
  entry_t                   newEntry;

  assign newEntry = decodeEntry(ctl.fullFmt, ctl.word);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slots[g] <= '0;
      else if (ctl.loadStb && slotSel[g])
        slots[g] <= newEntry;
    end
    assign match[g] = slots[g].valid && (slots[g].key == lkReg) && (slots[g].isInt == lkIsInt);
  end

  // Priority pick: walk downward so the lowest matching index is applied last.
  always_comb begin
    hit      = 1'b0;
    outReg   = {{(TGT_W-KEY_W){1'b0}}, lkReg};
    outVec   = 1'b0;
    outWidth = '0;
    for (int i = NUM_ENTRIES-1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        outReg   = slots[i].target;
        outVec   = slots[i].isVec;
        outWidth = slots[i].width;
      end
    end
  end

endmodule

// File: rtl/regmap_table.sv
module regmap_table
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               wrFull,
  input  logic [15:0]        wrData,
  input  logic [4:0]         lkReg,
  input  logic               lkIsInt,
  output logic               hit,
  output logic [6:0]         outReg,
  output logic               outVec,
  output logic [1:0]         outWidth
);

  ctl_t                   ctl;
  logic [NUM_ENTRIES-1:0] slotSel;

  regmap_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .wrEn    (wrEn),
    .wrIdx   (wrIdx),
    .wrFull  (wrFull),
    .wrData  (wrData),
    .ctl     (ctl),
    .slotSel (slotSel)
  );

  regmap_dp #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .slotSel  (slotSel),
    .lkReg    (lkReg),
    .lkIsInt  (lkIsInt),
    .hit      (hit),
    .outReg   (outReg),
    .outVec   (outVec),
    .outWidth (outWidth)
  );

endmodule

// File: rtl/regmap_chk.sv
module regmap_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx,
  input logic             wrFull,
  input logic [15:0]      wrData,
  input logic [4:0]       lkReg,
  input logic             lkIsInt,
  input logic             hit,
  input logic [6:0]       outReg,
  input logic             outVec,
  input logic [1:0]       outWidth
);

  // R1: the first sampled cycle out of reset sees an empty table
  a_r1_empty_after_reset: assert property (@(posedge clk) $rose(rstN) |-> !hit);

  // R2: miss passes the register through as a default-width scalar
  a_r2_miss_passthru: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (outReg == {2'b00, lkReg}) && !outVec && (outWidth == 2'b00));

  // R4: compact write to slot 0, then a lookup of its key, returns the shifted vector target
  a_r4_compact_slot0: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrFull && wrIdx == '0) |=>
      ((lkReg == $past(wrData[4:0]) && lkIsInt == $past(wrData[5])) ->
        (hit && outVec && outReg == {$past(wrData[4:0]), 2'b00} && outWidth == $past(wrData[7:6]))));

  // R5: full write to slot 0, then a lookup of its key, returns the explicit target
  a_r5_full_slot0: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrFull && wrIdx == '0) |=>
      ((lkReg == $past(wrData[4:0]) && lkIsInt == $past(wrData[5])) ->
        (hit && outReg == $past(wrData[14:8]) && outVec == !$past(wrData[15]))));

  // R8: with no write and steady lookup inputs, the result does not move
  a_r8_no_write_steady: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!wrEn) && $stable(lkReg) && $stable(lkIsInt)) |->
      ($stable(hit) && $stable(outReg) && $stable(outVec) && $stable(outWidth)));

endmodule

bind regmap_table regmap_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrFull(wrFull),
  .wrData(wrData), .lkReg(lkReg), .lkIsInt(lkIsInt), .hit(hit),
  .outReg(outReg), .outVec(outVec), .outWidth(outWidth)
);

// File: tb/sim_regmap_table.sv
module sim_regmap_table;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic        wrFull = 1'b0;
  logic [15:0] wrData = '0;
  logic [4:0]  lkReg = '0;
  logic        lkIsInt = 1'b0;
  logic        hit;
  logic [6:0]  outReg;
  logic        outVec;
  logic [1:0]  outWidth;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  regmap_table u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrFull(wrFull),
    .wrData(wrData), .lkReg(lkReg), .lkIsInt(lkIsInt), .hit(hit),
    .outReg(outReg), .outVec(outVec), .outWidth(outWidth)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  idx;
    logic        full;
    logic [15:0] data;
    logic [4:0]  reg_;
    logic        isInt;
    logic        eHit;
    logic [6:0]  eReg;
    logic        eVec;
    logic [1:0]  eWid;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 16'h0000, 5'd3,  1'b1, 1'b0, 7'h03, 1'b0, 2'd0, 4'd1}, // R1 empty table
    '{1'b1, 2'd1, 1'b0, 16'hFF45, 5'd5,  1'b0, 1'b1, 7'h14, 1'b1, 2'd1, 4'd4}, // R4 R6 compact, upper byte ignored
    '{1'b0, 2'd0, 1'b0, 16'h0000, 5'd5,  1'b1, 1'b0, 7'h05, 1'b0, 2'd0, 4'd3}, // R3 wrong bank misses
    '{1'b1, 2'd2, 1'b1, 16'hDAA7, 5'd7,  1'b1, 1'b1, 7'h5A, 1'b0, 2'd2, 4'd5}, // R5 full, scalar forced
    '{1'b1, 2'd3, 1'b1, 16'h33E7, 5'd7,  1'b1, 1'b1, 7'h5A, 1'b0, 2'd2, 4'd7}, // R7 slot 2 beats slot 3
    '{1'b1, 2'd0, 1'b0, 16'h0027, 5'd7,  1'b1, 1'b1, 7'h1C, 1'b1, 2'd0, 4'd7}, // R7 slot 0 beats all
    '{1'b1, 2'd0, 1'b1, 16'h7FC9, 5'd7,  1'b1, 1'b1, 7'h5A, 1'b0, 2'd2, 4'd9}, // R9 overwrite of slot 0
    '{1'b0, 2'd0, 1'b0, 16'h0000, 5'd9,  1'b0, 1'b1, 7'h7F, 1'b1, 2'd3, 4'd5}, // R5 R6 full, vector, 32-bit
    '{1'b0, 2'd0, 1'b0, 16'h0000, 5'd31, 1'b1, 1'b0, 7'h1F, 1'b0, 2'd0, 4'd2}, // R2 miss passthrough
    '{1'b1, 2'd1, 1'b0, 16'h00BF, 5'd31, 1'b1, 1'b1, 7'h7C, 1'b1, 2'd2, 4'd4}  // R4 top key shifted
  };

  task automatic checkOut(input string tag, input logic eHit, input logic [6:0] eReg,
                          input logic eVec, input logic [1:0] eWid);
    nChecks++;
    if (hit !== eHit || outReg !== eReg || outVec !== eVec || outWidth !== eWid) begin
      nFails++;
      $display("FAIL %s: got hit=%0b reg=%0h vec=%0b wid=%0d, expected hit=%0b reg=%0h vec=%0b wid=%0d",
               tag, hit, outReg, outVec, outWidth, eHit, eReg, eVec, eWid);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 during reset", 1'b0, 7'h00, 1'b0, 2'd0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VECS[i].we; wrIdx = VECS[i].idx; wrFull = VECS[i].full; wrData = VECS[i].data;
      lkReg = VECS[i].reg_; lkIsInt = VECS[i].isInt;
      @(posedge clk);
      #2;
      checkOut($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].eHit, VECS[i].eReg, VECS[i].eVec, VECS[i].eWid);
    end

    // R8: write is not visible before the edge, visible after it
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 2'd3; wrFull = 1'b0; wrData = 16'h0000;
    lkReg = 5'd0; lkIsInt = 1'b0;
    #1;
    checkOut("R8 before edge", 1'b0, 7'h00, 1'b0, 2'd0);
    @(posedge clk);
    #2;
    checkOut("R8 after edge", 1'b1, 7'h00, 1'b1, 2'd0);
    @(negedge clk) wrEn = 1'b0;

    // R1: reset in mid-run empties the table
    lkReg = 5'd9; lkIsInt = 1'b0;
    #1;
    checkOut("R5 before reset", 1'b1, 7'h7F, 1'b1, 2'd3);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    checkOut("R1 after reset", 1'b0, 7'h09, 1'b0, 2'd0);
    @(posedge clk);
    #2;
    finish_run();
  end

  initial begin
    repeat (2000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

endmodule